// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block holds a small set of recent page translations for a 32-bit virtual address space with 4 KB pages. A lookup splits the virtual address into a 20-bit page number and a 12-bit offset. It compares the page number against the tag of every entry at once. On a hit it returns the physical address, built from the stored physical page number and the unchanged offset. In the same cycle it checks the request's access type against that entry's read, write and execute permissions.

A lookup that finds no valid matching entry raises a miss. An external page-table walker then supplies the translation through the fill port, and it is installed on the next clock edge. A permission violation on a hit is reported on its own fault output, apart from the miss. A flush input invalidates every entry in a single cycle, for use when the address space changes.

Fills go first to the entry that already holds the same tag, then to the lowest-numbered free entry. When neither exists, they evict the entry chosen by a round-robin pointer.

Top module: `tlb_fa`

## Requirements
- R1: On a hit, `lkp_paddr_o` equals the matching entry's physical page number concatenated above the 12 low address bits, which pass through unchanged; with no hit, `lkp_paddr_o` is zero.
- R2: While `lkp_valid_i` is high, `lkp_hit_o` is high in the same cycle exactly when a valid entry's tag equals address bits [31:12].
- R3: `lkp_miss_o` is high exactly when `lkp_valid_i` is high and there is no hit; with `lkp_valid_i` low, hit, miss and fault are all low.
- R4: Access code 0 is read, 1 is write, 2 is execute and 3 is reserved. `lkp_fault_o` is high on a hit whose entry lacks the permission for the access code, and on every hit with code 3. `lkp_hit_o` stays high when a fault is raised.
- R5: A fill is written on the clock edge that ends the cycle in which `fill_valid_i` is high. A lookup in that same cycle still sees the old contents.
- R6: A fill whose page number is already held by a valid entry overwrites that entry, so no two valid entries share a tag.
- R7: A fill with no matching tag takes the lowest-numbered invalid entry and does not move the round-robin pointer.
- R8: A fill that finds every entry valid and no matching tag replaces the entry named by the round-robin pointer. The pointer then advances by one, wrapping from the last entry to entry 0. It starts at entry 0 after reset, and a flush does not move it.
- R9: `flush_i` clears every valid bit on the next edge, and a fill in the same cycle is dropped.
- R10: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| lkp_valid_i | input | 1 | Lookup request present |
| lkp_vaddr_i | input | 32 | Virtual address to translate |
| lkp_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| lkp_hit_o | output | 1 | Translation found |
| lkp_miss_o | output | 1 | No translation present |
| lkp_fault_o | output | 1 | Hit with a disallowed access |
| lkp_paddr_o | output | 32 | Translated physical address |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Virtual page number of the fill |
| fill_ppn_i | input | 20 | Physical page number of the fill |
| fill_rd_i | input | 1 | Read permitted |
| fill_wr_i | input | 1 | Write permitted |
| fill_ex_i | input | 1 | Execute permitted |

## Verification
The bench builds the block with four entries instead of sixteen. With four entries, a few fills fill the table, and the replacement pointer wraps several times within a short run. Every one of the eight permission combinations is tried against all four access codes. A reference model of the replacement rules predicts, after each fill, which page numbers must hit and which must miss. This covers duplicate overwrites, free-slot placement, eviction order and a flush that collides with a fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic ex;
    logic wr;
    logic rd;
  } perm_t;
endpackage

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  logic [1:0] acc_i,
  input  perm_t      perm_i,
  output logic       allow_o
);
  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_LOAD:  allow_o = perm_i.rd;
      ACC_STORE: allow_o = perm_i.wr;
      ACC_FETCH: allow_o = perm_i.ex;
      default:   allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  perm_t            wr_perm_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  output logic [N-1:0]     valid_o,
  output logic [N-1:0]     lkp_match_o,
  output logic [N-1:0]     fill_match_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output perm_t            hit_perm_o
);
  logic [PPN_W-1:0] ppn_arr  [N];
  perm_t            perm_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic             vld_q;
    logic [VPN_W-1:0] tag_q;
    logic [PPN_W-1:0] ppn_q;
    perm_t            perm_q;
    logic             sel;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      vld_q <= 1'b0;
      else if (flush_i) vld_q <= 1'b0;
      else if (sel)     vld_q <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q  <= '0;
        ppn_q  <= '0;
        perm_q <= '0;
      end else if (sel && !flush_i) begin
        tag_q  <= wr_vpn_i;
        ppn_q  <= wr_ppn_i;
        perm_q <= wr_perm_i;
      end
    end

    assign valid_o[g]      = vld_q;
    assign lkp_match_o[g]  = vld_q && (tag_q == lkp_vpn_i);
    assign fill_match_o[g] = vld_q && (tag_q == wr_vpn_i);
    assign ppn_arr[g]      = ppn_q;
    assign perm_arr[g]     = perm_q;
  end

  // AND-OR read mux; match vector is one-hot or empty
  always_comb begin
    hit_ppn_o  = '0;
    hit_perm_o = '0;
    for (int i = 0; i < N; i++) begin
      hit_ppn_o  = hit_ppn_o  | ({PPN_W{lkp_match_o[i]}} & ppn_arr[i]);
      hit_perm_o = hit_perm_o | ({3{lkp_match_o[i]}} & perm_arr[i]);
    end
  end

  p_no_dup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_match_o));

  p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_o == '0));

  p_fill_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !flush_i) |=> valid_o[$past(wr_idx_i)]);
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_en_i,
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     fill_match_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             evict_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] match_idx, free_idx;
  logic             any_match, any_free;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (fill_match_i[i]) match_idx = IDX_W'(i);
      if (!valid_i[i])     free_idx  = IDX_W'(i);
    end
  end

  assign any_match = |fill_match_i;
  assign any_free  = ~&valid_i;
  assign evict_o   = fill_en_i && !any_match && !any_free;

  always_comb begin
    if (any_match)     wr_idx_o = match_idx;
    else if (any_free) wr_idx_o = free_idx;
    else               wr_idx_o = rr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rr_q <= '0;
    else if (evict_o) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  p_free_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !any_match && any_free) |-> !valid_i[wr_idx_o]);

  p_dup_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && any_match) |-> fill_match_i[wr_idx_o]);

  p_rr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evict_o |=> (rr_q == $past(rr_q)));
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VA_W        = 32,
  parameter int PAGE_W      = 12,
  parameter int PPN_W       = 20,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PA_W  = PPN_W + PAGE_W,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             lkp_valid_i,
  input  logic [VA_W-1:0]  lkp_vaddr_i,
  input  logic [1:0]       lkp_acc_i,
  output logic             lkp_hit_o,
  output logic             lkp_miss_o,
  output logic             lkp_fault_o,
  output logic [PA_W-1:0]  lkp_paddr_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  input  logic             fill_ex_i
);
  logic [NUM_ENTRIES-1:0] valid, lkp_match, fill_match;
  logic [PPN_W-1:0]       hit_ppn;
  perm_t                  hit_perm, fill_perm;
  logic [IDX_W-1:0]       wr_idx;
  logic                   fill_en, evict, allow, any_hit;

  assign fill_en   = fill_valid_i && !flush_i;
  assign fill_perm = '{ex: fill_ex_i, wr: fill_wr_i, rd: fill_rd_i};

  tlb_entry_array #(
    .N(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .wr_en_i      (fill_en),
    .wr_idx_i     (wr_idx),
    .wr_vpn_i     (fill_vpn_i),
    .wr_ppn_i     (fill_ppn_i),
    .wr_perm_i    (fill_perm),
    .lkp_vpn_i    (lkp_vaddr_i[VA_W-1:PAGE_W]),
    .valid_o      (valid),
    .lkp_match_o  (lkp_match),
    .fill_match_o (fill_match),
    .hit_ppn_o    (hit_ppn),
    .hit_perm_o   (hit_perm)
  );

  tlb_victim_sel #(.N(NUM_ENTRIES)) u_victim (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_en_i    (fill_en),
    .valid_i      (valid),
    .fill_match_i (fill_match),
    .wr_idx_o     (wr_idx),
    .evict_o      (evict)
  );

  tlb_perm_check u_perm (
    .acc_i   (lkp_acc_i),
    .perm_i  (hit_perm),
    .allow_o (allow)
  );

  assign any_hit     = |lkp_match;
  assign lkp_hit_o   = lkp_valid_i && any_hit;
  assign lkp_miss_o  = lkp_valid_i && !any_hit;
  assign lkp_fault_o = lkp_hit_o && !allow;
  assign lkp_paddr_o = lkp_hit_o ? {hit_ppn, lkp_vaddr_i[PAGE_W-1:0]} : '0;

  p_hit_miss_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lkp_hit_o && lkp_miss_o));

  p_fault_on_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_fault_o |-> lkp_hit_o);

  p_offset_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> (lkp_paddr_o[PAGE_W-1:0] == lkp_vaddr_i[PAGE_W-1:0]));

  p_miss_after_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lkp_hit_o);

  p_evict_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict |-> (&valid));
endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [31:0] lkp_vaddr_i = '0;
  logic [1:0]  lkp_acc_i = '0;
  logic        lkp_hit_o, lkp_miss_o, lkp_fault_o;
  logic [31:0] lkp_paddr_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [19:0] fill_ppn_i = '0;
  logic        fill_rd_i = 1'b0, fill_wr_i = 1'b0, fill_ex_i = 1'b0;

  int checks = 0;
  int errors = 0;

  // reference state
  logic        m_vld  [N];
  logic [19:0] m_vpn  [N];
  logic [19:0] m_ppn  [N];
  logic [2:0]  m_perm [N];
  int          m_rr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tlb_fa #(.NUM_ENTRIES(N)) u_dut (
    .clk_i, .rst_ni, .flush_i, .lkp_valid_i, .lkp_vaddr_i, .lkp_acc_i,
    .lkp_hit_o, .lkp_miss_o, .lkp_fault_o, .lkp_paddr_o,
    .fill_valid_i, .fill_vpn_i, .fill_ppn_i, .fill_rd_i, .fill_wr_i, .fill_ex_i
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
    end
    m_rr = 0;
  endtask

  task automatic model_fill(input logic [19:0] vpn, input logic [19:0] ppn,
                            input logic [2:0] perm);
    int idx = -1;
    for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == vpn) idx = i;
    if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) idx = i;
    if (idx < 0) begin
      idx = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_vld[idx] = 1'b1; m_vpn[idx] = vpn; m_ppn[idx] = ppn; m_perm[idx] = perm;
  endtask

  // drive lookup at the falling edge, sample 1 time unit later
  task automatic lookup(input logic [31:0] va, input logic [1:0] acc,
                        input string req);
    logic        e_hit = 1'b0;
    logic [19:0] e_ppn = '0;
    logic [2:0]  e_perm = '0;
    logic        e_fault;
    logic [31:0] e_pa;
    @(negedge clk_i);
    lkp_valid_i = 1'b1; lkp_vaddr_i = va; lkp_acc_i = acc;
    #1;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_vpn[i] == va[31:12]) begin
        e_hit = 1'b1; e_ppn = m_ppn[i]; e_perm = m_perm[i];
      end
    e_fault = e_hit && ((acc == 2'd3) || !e_perm[acc]);
    e_pa    = e_hit ? {e_ppn, va[11:0]} : 32'h0;
    chk({lkp_hit_o, lkp_miss_o, lkp_fault_o} == {e_hit, !e_hit, e_fault}, req,
        {lkp_hit_o, lkp_miss_o, lkp_fault_o}, {e_hit, !e_hit, e_fault});
    chk(lkp_paddr_o == e_pa, req, lkp_paddr_o, e_pa);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic [2:0] perm);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn;
    {fill_ex_i, fill_wr_i, fill_rd_i} = perm;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    model_fill(vpn, ppn, perm);
  endtask

  task automatic flush();
    @(negedge clk_i);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 10; v++) lookup({20'h40000 + 20'(v), 12'h5A5}, 2'd0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10: empty after reset
    sweep("R10");
    // R3: idle lookup drives nothing
    @(negedge clk_i);
    lkp_valid_i = 1'b0;
    #1;
    chk({lkp_hit_o, lkp_miss_o, lkp_fault_o} == 3'b000, "R3", 
        {lkp_hit_o, lkp_miss_o, lkp_fault_o}, 3'b000);

    // R4 R1 R2: every permission set against every access code
    for (int p = 0; p < 8; p++) begin
      flush();
      fill(20'h12340 + 20'(p), 20'hABC00 + 20'(p), 3'(p));
      for (int a = 0; a < 4; a++)
        lookup({20'h12340 + 20'(p), 12'(p * 12'h111 + a)}, 2'(a), "R4");
      lookup({20'h12340 + 20'(p) + 20'h1, 12'h0}, 2'd0, "R2");
    end

    // R5: fill and lookup of the same page in one cycle
    flush();
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = 20'h77777; fill_ppn_i = 20'h0BEEF;
    {fill_ex_i, fill_wr_i, fill_rd_i} = 3'b001;
    lkp_valid_i = 1'b1; lkp_vaddr_i = 32'h77777123; lkp_acc_i = 2'd0;
    #1;
    chk(lkp_miss_o && !lkp_hit_o, "R5", {lkp_hit_o, lkp_miss_o}, 2'b01);
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    #1;
    chk(lkp_hit_o && lkp_paddr_o == 32'h0BEEF123, "R5", lkp_paddr_o, 32'h0BEEF123);
    model_fill(20'h77777, 20'h0BEEF, 3'b001);

    // R9: flush wins over a simultaneous fill
    fill(20'h40000, 20'h00100, 3'b111);
    fill(20'h40001, 20'h00101, 3'b111);
    @(negedge clk_i);
    flush_i = 1'b1; fill_valid_i = 1'b1; fill_vpn_i = 20'h40002;
    fill_ppn_i = 20'h00102;
    @(negedge clk_i);
    flush_i = 1'b0; fill_valid_i = 1'b0;
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    sweep("R9");
    lookup(32'h77777000, 2'd0, "R9");

    // R7: free slots fill without eviction
    for (int v = 0; v < N; v++) begin
      fill(20'h40000 + 20'(v), 20'h00200 + 20'(v), 3'b111);
      sweep("R7");
    end

    // R6: duplicate tag overwrites in place
    fill(20'h40002, 20'h00999, 3'b010);
    sweep("R6");
    lookup(32'h40002ABC, 2'd1, "R6");
    lookup(32'h40002ABC, 2'd0, "R6");

    // R8: round-robin eviction through several wraps
    for (int v = N; v < 10; v++) begin
      fill(20'h40000 + 20'(v), 20'h00300 + 20'(v), 3'b101);
      sweep("R8");
    end
    flush();
    for (int v = 0; v < 7; v++) begin
      fill(20'h40000 + 20'(v), 20'h00400 + 20'(v), 3'b100);
      sweep("R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule